// File: doc/BRIEF.md
# Flash Erase Verify Command Engine

This block runs a read-ones verify command against a flash array. Software loads a six-byte parameter vector and pulses launch. The block captures the parameters and the side inputs (margin code, region select, emulated-EEPROM enable, command permission). It spends one cycle validating them. If they pass, it walks a range of 64-bit array words through a synchronous read port with one cycle of latency and checks that every word reads as all ones.

Two modes exist. Block mode verifies the whole selected region. Section mode verifies a start address plus a count of units. In the program region a unit is a 128-bit double-phrase (two words) when that region is interleaved. In the data region a unit is a 64-bit phrase (one word). A rejected command sets an access-error flag and performs no reads. A walk that meets a word with any zero bit sets a sticky verify-fail flag and still runs to the end of the range. A completion flag is low while a command runs and goes high when the command ends.

Top module: `fv_erase_verify`

## Requirements
- R1: After reset, done_o is 1, acc_err_o and vfail_o are 0, and rd_en_o is 0.
- R2: A launch_i pulse is accepted only while done_o is 1. Acceptance makes done_o 0 from the next cycle, clears acc_err_o and vfail_o, and captures the parameters. A launch_i pulse while done_o is 0 changes nothing.
- R3: Parameter byte k sits at prm_i[8k+7:8k]. Byte 0 is the opcode: 0x00 selects block mode and 0x01 selects section mode. Any other opcode sets acc_err_o. Bytes 1, 2 and 3 hold address bits [23:16], [15:8] and [7:0]. Bytes 4 and 5 hold the unit count, high byte first.
- R4: A margin_i code above 0x02 sets acc_err_o. During reads, rd_margin_o carries the accepted margin code.
- R5: The start address must be a multiple of 16 in the program region (region_i = 0, interleaved) and a multiple of 8 in the data region (region_i = 1). Otherwise acc_err_o is set.
- R6: acc_err_o is set in any of these cases: the start address lies outside the selected region; in section mode the count is zero; in section mode start plus count times the unit size passes the region end.
- R7: acc_err_o is set when the data region is selected while eeprom_en_i is 1, or when cmd_ok_i is 0.
- R8: A rejected command performs no reads, and done_o returns to 1 two cycles after the accepting edge, with acc_err_o set.
- R9: An accepted command issues one read per cycle, starting in the second cycle after the accepting edge. Byte addresses step by 8. Section mode covers count × 2 words in the program region or count words in the data region. Block mode covers the whole region from its base.
- R10: If any word read has a zero bit, vfail_o is set. The walk still covers the full range, and vfail_o stays set until the next accepted launch.
- R11: done_o rises two cycles after the cycle that issued the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Command launch pulse |
| prm_i | input | 48 | Parameter bytes 0..5 |
| margin_i | input | 8 | Read margin code |
| region_i | input | 1 | 0 program region, 1 data region |
| eeprom_en_i | input | 1 | Emulated EEPROM enabled |
| cmd_ok_i | input | 1 | Command allowed in current mode/security |
| rd_en_o | output | 1 | Array read strobe |
| rd_addr_o | output | 24 | Byte address of the 64-bit word read |
| rd_margin_o | output | 2 | Margin level applied to the read |
| rd_data_i | input | 64 | Read data, valid one cycle after rd_en_o |
| done_o | output | 1 | Command complete |
| acc_err_o | output | 1 | Access error |
| vfail_o | output | 1 | Verify failure (sticky) |

## Verification
The walk is driven with section ranges in both regions and with full-block walks in both regions, against an array that is fully erased. These runs separate the unit stride of the two regions and the count-to-word scaling. Single zero words placed inside a range, including one early in the walk, show that the fail flag latches and that the walk does not stop early. Each rejection cause is applied on its own: bad opcode, bad margin, misalignment, start out of range, span overrun, zero count, EEPROM conflict and a forbidden command. Each is preceded by passing commands, so that flag clearing and the absence of reads are both visible. A launch pulse inside a running walk checks that a busy engine ignores it.

// File: rtl/fv_pkg.sv
package fv_pkg;
  localparam int ADDR_W    = 24;
  localparam int PRM_BYTES = 6;
  localparam logic [7:0] OP_BLOCK   = 8'h00;
  localparam logic [7:0] OP_SECTION = 8'h01;
  localparam logic [7:0] MARGIN_MAX = 8'h02;

  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_RD, ST_DRAIN} fv_state_e;
endpackage

// File: rtl/fv_param_check.sv
module fv_param_check
  import fv_pkg::*;
#(
  parameter int          CNT_W          = 16,
  parameter int unsigned PF_BASE        = 0,
  parameter int unsigned PF_SIZE        = 256,
  parameter int unsigned DF_BASE        = 32'h80_0000,
  parameter int unsigned DF_SIZE        = 128,
  parameter bit          PF_INTERLEAVED = 1'b1,
  parameter int          WC_W           = ADDR_W
) (
  input  logic [8*PRM_BYTES-1:0] prm_i,
  input  logic [7:0]             margin_i,
  input  logic                   region_i,
  input  logic                   eeprom_en_i,
  input  logic                   cmd_ok_i,
  output logic                   err_o,
  output logic [ADDR_W-1:0]      start_o,
  output logic [WC_W-1:0]        nwords_o
);
  localparam int EW          = ADDR_W + CNT_W + 6;
  localparam int PF_UNIT     = PF_INTERLEAVED ? 16 : 8;
  localparam int DF_UNIT     = 8;
  localparam int PF_WPU      = PF_UNIT / 8;
  localparam int DF_WPU      = DF_UNIT / 8;

  logic [7:0]        code;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic [EW-1:0]     unit, base, lim, a_ext, span;
  logic [WC_W-1:0]   wpu, blk_words;
  logic              is_sec, bad_op, misalign, oor, sec_bad;

  always_comb begin
    code  = prm_i[7:0];
    addr  = {prm_i[15:8], prm_i[23:16], prm_i[31:24]};
    cnt   = CNT_W'({prm_i[39:32], prm_i[47:40]});
    unit  = region_i ? EW'(DF_UNIT) : EW'(PF_UNIT);
    wpu   = region_i ? WC_W'(DF_WPU) : WC_W'(PF_WPU);
    base  = region_i ? EW'(DF_BASE) : EW'(PF_BASE);
    lim   = base + (region_i ? EW'(DF_SIZE) : EW'(PF_SIZE));
    blk_words = region_i ? WC_W'(DF_SIZE / 8) : WC_W'(PF_SIZE / 8);
    a_ext = EW'(addr);
    span  = a_ext + EW'(cnt) * unit;

    is_sec   = (code == OP_SECTION);
    bad_op   = (code != OP_BLOCK) && !is_sec;
    misalign = (a_ext & (unit - EW'(1))) != '0;
    oor      = (a_ext < base) || (a_ext >= lim);
    sec_bad  = is_sec && ((cnt == '0) || (span > lim));

    err_o    = !cmd_ok_i || (margin_i > MARGIN_MAX) || bad_op ||
               (region_i && eeprom_en_i) || misalign || oor || sec_bad;
    start_o  = is_sec ? addr : base[ADDR_W-1:0];
    nwords_o = is_sec ? WC_W'(cnt) * wpu : blk_words;
  end
endmodule

// File: rtl/fv_walker.sv
module fv_walker
  import fv_pkg::*;
#(
  parameter int WC_W = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WC_W-1:0]   nwords_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [WC_W-1:0]   left_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      addr_q <= addr_i;
      left_q <= nwords_i;
      busy_q <= nwords_i != '0;
    end else if (busy_q) begin
      addr_q <= addr_q + ADDR_W'(8);
      left_q <= left_q - WC_W'(1);
      if (left_q == WC_W'(1)) busy_q <= 1'b0;
    end
  end

  assign rd_en_o   = busy_q;
  assign rd_addr_o = addr_q;
  assign last_o    = busy_q && (left_q == WC_W'(1));
endmodule

// File: rtl/fv_erase_verify.sv
module fv_erase_verify
  import fv_pkg::*;
#(
  parameter int          CNT_W          = 16,
  parameter int          WORD_W         = 64,
  parameter int unsigned PF_BASE        = 0,
  parameter int unsigned PF_SIZE        = 256,
  parameter int unsigned DF_BASE        = 32'h80_0000,
  parameter int unsigned DF_SIZE        = 128,
  parameter bit          PF_INTERLEAVED = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   launch_i,
  input  logic [8*PRM_BYTES-1:0] prm_i,
  input  logic [7:0]             margin_i,
  input  logic                   region_i,
  input  logic                   eeprom_en_i,
  input  logic                   cmd_ok_i,
  output logic                   rd_en_o,
  output logic [ADDR_W-1:0]      rd_addr_o,
  output logic [1:0]             rd_margin_o,
  input  logic [WORD_W-1:0]      rd_data_i,
  output logic                   done_o,
  output logic                   acc_err_o,
  output logic                   vfail_o
);
  localparam int WC_W = ADDR_W;

  fv_state_e             st_q;
  logic [8*PRM_BYTES-1:0] prm_q;
  logic [7:0]            margin_q;
  logic                  region_q, ee_q, ok_q;
  logic                  chk_err, walk_last, rd_vld_q, accept;
  logic [ADDR_W-1:0]     chk_start;
  logic [WC_W-1:0]       chk_nwords;

  fv_param_check #(
    .CNT_W(CNT_W), .PF_BASE(PF_BASE), .PF_SIZE(PF_SIZE),
    .DF_BASE(DF_BASE), .DF_SIZE(DF_SIZE),
    .PF_INTERLEAVED(PF_INTERLEAVED), .WC_W(WC_W)
  ) u_chk_prm (
    .prm_i(prm_q), .margin_i(margin_q), .region_i(region_q),
    .eeprom_en_i(ee_q), .cmd_ok_i(ok_q),
    .err_o(chk_err), .start_o(chk_start), .nwords_o(chk_nwords)
  );

  fv_walker #(.WC_W(WC_W)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(st_q == ST_CHK && !chk_err),
    .addr_i(chk_start), .nwords_i(chk_nwords),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .last_o(walk_last)
  );

  assign accept      = (st_q == ST_IDLE) && launch_i;
  assign done_o      = (st_q == ST_IDLE);
  assign rd_margin_o = margin_q[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      prm_q     <= '0;
      margin_q  <= '0;
      region_q  <= 1'b0;
      ee_q      <= 1'b0;
      ok_q      <= 1'b0;
      acc_err_o <= 1'b0;
      vfail_o   <= 1'b0;
      rd_vld_q  <= 1'b0;
    end else begin
      rd_vld_q <= rd_en_o;
      // one-cycle read latency: compare the word requested last cycle
      if (rd_vld_q && (rd_data_i != '1)) vfail_o <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          prm_q     <= prm_i;
          margin_q  <= margin_i;
          region_q  <= region_i;
          ee_q      <= eeprom_en_i;
          ok_q      <= cmd_ok_i;
          acc_err_o <= 1'b0;
          vfail_o   <= 1'b0;
          st_q      <= ST_CHK;
        end
        ST_CHK: begin
          if (chk_err) begin
            acc_err_o <= 1'b1;
            st_q      <= ST_IDLE;
          end else begin
            st_q <= ST_RD;
          end
        end
        ST_RD:    if (walk_last) st_q <= ST_DRAIN;
        ST_DRAIN: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fv_erase_verify_chk.sv
module fv_erase_verify_chk
  import fv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              launch_i,
  input logic              done_o,
  input logic              acc_err_o,
  input logic              vfail_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o
);
  AST_LAUNCH_DROPS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && launch_i) |=> !done_o);  // R2

  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !launch_i) |=> ($stable(acc_err_o) && $stable(vfail_o)));  // R10

  AST_NO_READ_WHEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> !done_o);  // R9

  AST_ERR_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> !rd_en_o);  // R8

  AST_READ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_addr_o[2:0] == 3'b000));  // R5

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + ADDR_W'(8)));  // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_err_o && vfail_o));  // R8
endmodule

bind fv_erase_verify fv_erase_verify_chk u_fv_chk (.*);

// File: tb/tb_fv_erase_verify.sv
`timescale 1ns/1ps
module tb_fv_erase_verify;
  localparam int unsigned DF_BASE = 32'h80_0000;
  localparam int unsigned PF_SIZE = 256;
  localparam int unsigned DF_SIZE = 128;
  localparam int NWORDS = (PF_SIZE + DF_SIZE) / 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch = 1'b0;
  logic [47:0] prm = '0;
  logic [7:0]  margin = '0;
  logic        region = 1'b0, eeprom_en = 1'b0, cmd_ok = 1'b1;
  logic        rd_en, done, acc_err, vfail;
  logic [23:0] rd_addr;
  logic [1:0]  rd_margin;
  logic [63:0] rd_data = '0;
  logic [63:0] mem [NWORDS];

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  fv_erase_verify dut (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .prm_i(prm),
    .margin_i(margin), .region_i(region), .eeprom_en_i(eeprom_en),
    .cmd_ok_i(cmd_ok), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_margin_o(rd_margin), .rd_data_i(rd_data), .done_o(done),
    .acc_err_o(acc_err), .vfail_o(vfail)
  );

  function automatic int widx(int unsigned a);
    if (a >= DF_BASE) return PF_SIZE / 8 + int'((a - DF_BASE) >> 3);
    return int'(a >> 3);
  endfunction

  always @(posedge clk) begin
    if (rd_en && widx(rd_addr) < NWORDS) rd_data <= mem[widx(rd_addr)];
    else if (rd_en) rd_data <= '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: predicts rejection, read stream and completion per cycle
  task automatic run(string req, bit [7:0] op, int unsigned addr, int cnt,
                     bit [7:0] mg, bit rg, bit ee, bit ok, bit mid_launch);
    int unsigned unit, base, lim, start;
    int n, total;
    bit err, exp_fail;
    unit = rg ? 8 : 16;
    base = rg ? DF_BASE : 0;
    lim  = base + (rg ? DF_SIZE : PF_SIZE);
    err  = !ok || mg > 2 || (op != 8'h00 && op != 8'h01) || (rg && ee) ||
           (addr % unit) != 0 || addr < base || addr >= lim ||
           (op == 8'h01 && (cnt == 0 || longint'(addr) + longint'(cnt) * unit > lim));
    start = (op == 8'h01) ? addr : base;
    n = err ? 0 : ((op == 8'h01) ? cnt * int'(unit / 8) : int'((lim - base) / 8));
    exp_fail = 1'b0;
    for (int i = 0; i < n; i++)
      if (mem[widx(start + 8 * i)] != '1) exp_fail = 1'b1;
    total = err ? 2 : n + 3;

    @(negedge clk);
    prm = {cnt[7:0], cnt[15:8], addr[7:0], addr[15:8], addr[23:16], op};
    margin = mg; region = rg; eeprom_en = ee; cmd_ok = ok;
    launch = 1'b1;
    for (int k = 1; k <= total; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) begin
        launch = 1'b0;
        chk("R2", "flags cleared on launch", {acc_err, vfail}, 0);
      end
      chk(k == total ? "R11" : "R2", "done", done, k == total);
      chk(err ? "R8" : "R9", "rd_en", rd_en, !err && k >= 2 && k <= n + 1);
      if (rd_en && !err && k >= 2 && k <= n + 1) begin
        chk("R9", "rd_addr", rd_addr, start + 8 * (k - 2));
        chk("R4", "rd_margin", rd_margin, mg[1:0]);
      end
      if (mid_launch && k == 3) begin
        launch = 1'b1;
        prm[7:0] = 8'h07;
        margin = 8'hFF;
      end
      if (mid_launch && k == 4) launch = 1'b0;
    end
    chk(req, "acc_err", acc_err, err);
    chk(err ? req : "R10", "vfail", vfail, exp_fail);
    @(negedge clk);
    chk("R2", "stays done", done, 1);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = '1;
    repeat (3) @(negedge clk);
    chk("R1", "reset done", done, 1);
    chk("R1", "reset flags", {acc_err, vfail}, 0);
    chk("R1", "reset rd_en", rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R9",  8'h01, 24'h000010, 3, 8'h00, 0, 0, 1, 1);   // busy launch ignored
    run("R9",  8'h01, DF_BASE + 8, 4, 8'h01, 1, 0, 1, 0);
    run("R9",  8'h00, 24'h000000, 0, 8'h02, 0, 0, 1, 0);
    mem[PF_SIZE / 8 + 5] = 64'hFFFF_FFFF_FFFF_FFFE;
    run("R10", 8'h00, DF_BASE, 0, 8'h00, 1, 0, 1, 0);
    mem[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    run("R10", 8'h01, 24'h000010, 4, 8'h00, 0, 0, 1, 0);
    run("R4",  8'h01, 24'h000010, 1, 8'h03, 0, 0, 1, 0);
    run("R3",  8'h02, 24'h000010, 1, 8'h00, 0, 0, 1, 0);
    run("R9",  8'h01, 24'h000020, 2, 8'h00, 0, 0, 1, 0);  // clears earlier error
    run("R5",  8'h01, 24'h000008, 1, 8'h00, 0, 0, 1, 0);
    run("R5",  8'h01, DF_BASE + 4, 1, 8'h00, 1, 0, 1, 0);
    run("R6",  8'h01, 24'h0000F0, 2, 8'h00, 0, 0, 1, 0);
    run("R6",  8'h00, 24'h000100, 0, 8'h00, 0, 0, 1, 0);
    run("R6",  8'h01, DF_BASE, 0, 8'h00, 1, 0, 1, 0);
    run("R7",  8'h01, DF_BASE, 1, 8'h00, 1, 1, 1, 0);
    run("R7",  8'h01, 24'h000000, 1, 8'h00, 0, 0, 0, 0);
    run("R9",  8'h01, 24'h0000F0, 1, 8'h00, 0, 0, 1, 0);  // last unit of region

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule